// File: doc/BRIEF.md
# Cascadable Parallel Configuration Byte Streamer

This block is the read side of a byte-wide configuration store that feeds a target device while that device configures itself over a parallel bus. A fixed image of `DEPTH` bytes is built inside the block from a seed parameter, so no external file is needed. One byte at a time appears on an 8-bit bus, taken from an internal address counter. The counter moves forward by one on each rising clock edge where the stream is allowed to move.

The target controls the pace of the stream. It can stall it with a busy input. It restarts the stream from the first byte by pulling the combined output-enable/reset input low. An active-low chip enable gates the whole block. When the image has been fully read, an active-low cascade output goes low. It is meant to drive the chip enable of a second instance, so that chained instances present their images back to back as one stream.

Instead of a tri-stated bus, a valid flag marks when the data bus carries a byte. While the flag is low, the data bus reads zero.

Top module: `cfg_byte_streamer`

## Requirements
- R1: While `oeRstN` is low the address counter is held at zero, `dataValid` is low and `dataOut` is zero. After `oeRstN` rises, the first byte presented is image byte 0.
- R2: Image byte k (0 <= k < DEPTH) equals (SEED + 37*k) mod 256.
- R3: A clock edge is qualifying when `ceN` is low, `oeRstN` is high, `busy` is low and the image is not exhausted. Each qualifying edge moves the presented byte from image byte k to image byte k+1.
- R4: While `busy` is high the presented byte stays unchanged and the counter does not advance.
- R5: While `ceN` is high, `dataValid` is low, `dataOut` is zero and the counter holds. When `ceN` returns low, the byte that was current before is presented again.
- R6: Once DEPTH bytes have been consumed, the image is exhausted. In that state `dataValid` is low, `dataOut` is zero, the counter stops, and `ceoN` is low while `ceN` is low.
- R7: `ceoN` is high whenever `ceN` is high or the image is not exhausted. A low pulse on `oeRstN` clears the exhausted state, so `ceoN` returns high.
- R8: When the `ceoN` of one instance drives the `ceN` of a second, the merged stream is the first image followed directly by the second. No cycle is lost or repeated at the handoff, even when `busy` is asserted at the handoff.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock; the counter advances on its rising edge |
| ceN | input | 1 | Active-low chip enable |
| oeRstN | input | 1 | Output enable when high; asynchronous counter reset when low |
| busy | input | 1 | Stall request from the target |
| dataOut | output | 8 | Presented image byte, zero when not valid |
| dataValid | output | 1 | High when `dataOut` carries a byte |
| ceoN | output | 1 | Active-low cascade enable for the next instance |

## Verification
A corrupted address counter shows up on `dataOut` in the same cycle: the wrong image byte appears, and a skipped or repeated byte breaks the expected sequence at the very next sample. An error in the exhausted state shows either as `ceoN` falling one or more bytes early or late, or as `dataValid` staying high after the last byte. In a chain, either fault is seen at the handoff as a gap or a duplicated byte in the merged stream. A stall or enable fault appears within one clock edge, because `dataOut` changes while `busy` is high or the position is lost across a chip-enable gap.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic advance;
    logic drive;
  } strobe_t;

  // image content generator
  function automatic logic [7:0] imageByte(input logic [7:0] seed, input int unsigned idx);
    logic [31:0] prod;
    prod = idx * 32'd37;
    return seed + prod[7:0];
  endfunction

endpackage

// File: rtl/cfg_stream_ctrl.sv
module cfg_stream_ctrl
  import cfg_stream_pkg::*;
(
  input  logic    ceN,
  input  logic    oeRstN,
  input  logic    busy,
  input  logic    exhausted,
  output strobe_t stb,
  output logic    ceoN
);

  always_comb begin
    stb.drive   = !ceN && oeRstN && !exhausted;
    stb.advance = !ceN && oeRstN && !exhausted && !busy;
    ceoN        = !(exhausted && !ceN);
  end

endmodule

// File: rtl/cfg_stream_dp.sv
module cfg_stream_dp
  import cfg_stream_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter logic [7:0]  SEED  = 8'h5A
) (
  input  logic       clk,
  input  logic       oeRstN,
  input  strobe_t    stb,
  output logic       exhausted,
  output logic [7:0] dataOut,
  output logic       dataValid
);

  localparam int unsigned AW = $clog2(DEPTH + 1);
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH);

  logic [7:0]    image [DEPTH];
  logic [AW-1:0] addr;
  logic [IW-1:0] rdIdx;

  for (genvar i = 0; i < DEPTH; i++) begin : g_img
    assign image[i] = imageByte(SEED, i);
  end

  always_ff @(posedge clk or negedge oeRstN) begin
    if (!oeRstN)          addr <= '0;
    else if (stb.advance) addr <= addr + AW'(1);
  end

  always_comb begin
    exhausted = (addr == LAST);
    rdIdx     = exhausted ? '0 : addr[IW-1:0];
    dataValid = stb.drive;
    dataOut   = stb.drive ? image[rdIdx] : 8'h00;
  end

endmodule

// File: rtl/cfg_byte_streamer.sv
module cfg_byte_streamer
  import cfg_stream_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter logic [7:0]  SEED  = 8'h5A
) (
  input  logic       clk,
  input  logic       ceN,
  input  logic       oeRstN,
  input  logic       busy,
  output logic [7:0] dataOut,
  output logic       dataValid,
  output logic       ceoN
);

  strobe_t stb;
  logic    exhausted;

  cfg_stream_ctrl u_ctrl (
    .ceN      (ceN),
    .oeRstN   (oeRstN),
    .busy     (busy),
    .exhausted(exhausted),
    .stb      (stb),
    .ceoN     (ceoN)
  );

  cfg_stream_dp #(.DEPTH(DEPTH), .SEED(SEED)) u_dp (
    .clk      (clk),
    .oeRstN   (oeRstN),
    .stb      (stb),
    .exhausted(exhausted),
    .dataOut  (dataOut),
    .dataValid(dataValid)
  );

endmodule

// File: rtl/cfg_byte_streamer_chk.sv
module cfg_byte_streamer_chk (
  input logic       clk,
  input logic       ceN,
  input logic       oeRstN,
  input logic       busy,
  input logic [7:0] dataOut,
  input logic       dataValid,
  input logic       ceoN
);

  assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!oeRstN)
    (dataValid && busy) |=> (!dataValid || $stable(dataOut)));

  assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!oeRstN)
    ceN |-> (!dataValid && dataOut == 8'h00));

  assert_ceo_no_data_R6: assert property (@(posedge clk) disable iff (!oeRstN)
    !ceoN |-> !dataValid);

  assert_ceo_sticky_R6: assert property (@(posedge clk) disable iff (!oeRstN)
    (!ceoN && !ceN) |=> (ceN || !ceoN));

  assert_ceo_gated_R7: assert property (@(posedge clk) disable iff (!oeRstN)
    ceN |-> ceoN);

endmodule

bind cfg_byte_streamer cfg_byte_streamer_chk u_chk (
  .clk      (clk),
  .ceN      (ceN),
  .oeRstN   (oeRstN),
  .busy     (busy),
  .dataOut  (dataOut),
  .dataValid(dataValid),
  .ceoN     (ceoN)
);

// File: tb/cfg_byte_streamer_tb.sv
module cfg_byte_streamer_tb;

  localparam int unsigned DA = 8;
  localparam int unsigned DB = 5;
  localparam logic [7:0]  SA = 8'h11;
  localparam logic [7:0]  SB = 8'hA0;
  localparam int unsigned NV = 20;
  // {busy, expected merged index}; index 13 means stream finished
  localparam logic [4:0] TBL [NV] = '{
    5'h00, 5'h11, 5'h11, 5'h01, 5'h02, 5'h03, 5'h14, 5'h04, 5'h05, 5'h06,
    5'h07, 5'h18, 5'h08, 5'h09, 5'h1A, 5'h0A, 5'h0B, 5'h0C, 5'h0D, 5'h1D
  };

  logic clk = 1'b0;
  logic ceN, oeRstN, busy;
  logic [7:0] aData, bData;
  logic aValid, bValid, aCeoN, bCeoN;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  cfg_byte_streamer #(.DEPTH(DA), .SEED(SA)) u_dut (
    .clk(clk), .ceN(ceN), .oeRstN(oeRstN), .busy(busy),
    .dataOut(aData), .dataValid(aValid), .ceoN(aCeoN)
  );

  cfg_byte_streamer #(.DEPTH(DB), .SEED(SB)) u_next (
    .clk(clk), .ceN(aCeoN), .oeRstN(oeRstN), .busy(busy),
    .dataOut(bData), .dataValid(bValid), .ceoN(bCeoN)
  );

  function automatic logic [8:0] expOf(input int idx);
    logic [31:0] p;
    if (idx < int'(DA)) begin
      p = idx * 37;
      return {1'b1, SA + p[7:0]};
    end
    if (idx < int'(DA + DB)) begin
      p = (idx - int'(DA)) * 37;
      return {1'b1, SB + p[7:0]};
    end
    return 9'h000;
  endfunction

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    ceN = 1'b0; oeRstN = 1'b0; busy = 1'b0;
    @(negedge clk); @(negedge clk);
    #1;
    chk("R1 reset outputs", {aValid, aData}, 9'h000);
    chk("R7 reset ceoN", {8'h00, aCeoN}, 9'h001);
    @(negedge clk);
    oeRstN = 1'b1;

    // chained stream walk (R2 R3 R4 R8)
    for (int k = 0; k < int'(NV); k++) begin
      busy = TBL[k][4];
      #1;
      chk("R8 merged stream", {aValid | bValid, aData | bData}, expOf(int'(TBL[k][3:0])));
      chk("R6 first ceoN", {8'h00, aCeoN}, {8'h00, (int'(TBL[k][3:0]) < int'(DA))});
      @(negedge clk);
    end
    #1;
    chk("R6 end of chain ceoN", {8'h00, bCeoN}, 9'h000);

    // mid-stream reset pulse (R1)
    @(negedge clk);
    oeRstN = 1'b0; busy = 1'b0; ceN = 1'b0;
    #1;
    chk("R1 reset pulse quiet", {aValid, aData}, 9'h000);
    @(negedge clk);
    oeRstN = 1'b1;
    #1;
    chk("R1 restart at byte 0", {aValid, aData}, expOf(0));

    // chip enable gap (R5)
    repeat (3) @(negedge clk);
    ceN = 1'b1;
    #1;
    chk("R5 disabled outputs", {aValid, aData}, 9'h000);
    chk("R7 ceoN high while disabled", {8'h00, aCeoN}, 9'h001);
    repeat (3) @(negedge clk);
    ceN = 1'b0;
    #1;
    chk("R5 position held", {aValid, aData}, expOf(3));

    // exhaustion (R6 R7)
    repeat (5) @(negedge clk);
    #1;
    chk("R6 exhausted quiet", {aValid, aData}, 9'h000);
    chk("R6 exhausted ceoN", {8'h00, aCeoN}, 9'h000);
    repeat (2) @(negedge clk);
    #1;
    chk("R6 stays exhausted", {aValid, aCeoN, aData}, 10'h000);
    @(negedge clk);
    ceN = 1'b1;
    #1;
    chk("R7 ceoN follows ceN", {8'h00, aCeoN}, 9'h001);
    @(negedge clk);
    ceN = 1'b0;
    #1;
    chk("R7 ceoN returns", {8'h00, aCeoN}, 9'h000);
    @(negedge clk);
    oeRstN = 1'b0;
    #1;
    chk("R7 reset clears ceoN", {8'h00, aCeoN}, 9'h001);
    @(negedge clk);
    oeRstN = 1'b1;
    busy = 1'b1;
    #1;
    chk("R1 byte 0 after reset", {aValid, aData}, expOf(0));

    // long stall (R4) then one advance (R3)
    for (int s = 0; s < 5; s++) begin
      @(negedge clk);
      #1;
      chk("R4 busy holds byte", {aValid, aData}, expOf(0));
    end
    busy = 1'b0;
    @(negedge clk);
    busy = 1'b1;
    #1;
    chk("R3 single advance", {aValid, aData}, expOf(1));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule